// File: doc/BRIEF.md
# Vertical-Sync-Clocked Display Identification Transmitter

This block sends display identification bytes on a one-way serial data line. The bit clock is the video vertical-sync input rather than a baud generator. A host CPU writes each byte into a one-byte holding register. The block moves that byte into a shift register and raises an interrupt flag, so the CPU can supply the following byte while the current one goes out.

Each frame takes nine rising edges of vertical sync. The first eight edges carry the data bits, most significant bit first by default. The ninth edge drives a zero into the acknowledge slot, and at that same edge the next byte is loaded into the shifter. Vertical sync is asynchronous to the system clock, so it passes through a synchronizer before its rising edge is detected.

A single enable input gates the block. While the enable is low, the line rests high so that another port can use the pins. If the CPU has not refilled the holding register when a byte is loaded, the old contents are sent again and a sticky underrun flag is set.

Top module: `vsync_ddc_tx`

## Requirements
- R1: Every frame is nine slots. Eight data slots are followed by one slot in which `sd_out` is driven to 0.
- R2: `sd_out` changes only in response to a rising edge of `vsync_in`. With the default two synchronizer stages, if `vsync_in` is first sampled high at clock edge k, the new slot value appears after edge k+2. A falling edge, or a level held high, causes no advance. `vsync_in` must stay high for at least two clocks and low for at least two clocks.
- R3: With `MSB_FIRST`=1, data bits go out from bit 7 down to bit 0.
- R4: A one-cycle `wr_en` stores `wr_data` in the holding register, marks it full, and clears `irq` on the next clock edge. Writes are accepted whether or not `en` is high.
- R5: Every transfer from the holding register into the shifter sets `irq` on the same clock edge.
- R6: On the first clock edge with `en` high after it was low, the held byte loads into the shifter and `irq` sets. `sd_out` stays 1 until the next vsync rising edge, which drives the first data bit.
- R7: While `en` is low, `sd_out` is 1, vsync edges are ignored, the frame position returns to the first data slot, and both `irq` and `underrun` are 0.
- R8: A one-cycle `irq_clr` clears `irq` on the next edge, unless a transfer happens on that same edge.
- R9: A transfer made while the holding register is not full sends the previous register contents again and sets `underrun`. `underrun` stays 1 until `en` goes low.
- R10: The edge that drives the acknowledge slot also loads the next byte, so the following vsync rising edge drives that byte's first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low parks the line high |
| wr_en | input | 1 | One-cycle strobe that writes the holding register |
| wr_data | input | DATA_W | Byte for the holding register |
| irq_clr | input | 1 | One-cycle strobe that clears the interrupt flag |
| vsync_in | input | 1 | Asynchronous vertical-sync bit clock |
| sd_out | output | 1 | Serial data line |
| irq | output | 1 | Level interrupt that asks for the next byte |
| underrun | output | 1 | Sticky flag: a byte was resent for lack of a refill |

## Verification
The serial output is due two clock edges after the edge that first samples vsync high, because it passes through two synchronizer flops and then the output register. The bench drives vsync on falling clock edges. It checks a single transition at the exact sample on either side of that edge, and checks every other slot only after vsync has been held for eight clocks. Register writes, the interrupt clear and the enable load all take effect on the first rising edge after the stimulus. The bench drives each one on a falling edge and reads the result on a later falling edge, away from the edge where the design updates.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
   // Line level while parked or waiting for the first bit
   localparam logic LINE_IDLE = 1'b1;
   // Level forced into the acknowledge slot of every frame
   localparam logic LINE_ACK = 1'b0;
   // Fewest flops allowed in the vsync synchronizer
   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/vsr_sync_edge.sv
module vsr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   import vsr_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("vsr_sync_edge: STAGES below minimum");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R2
endmodule

// File: rtl/vsr_hold_buf.sv
module vsr_hold_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              irq_clr,
   input  logic              load_req,
   output logic [DATA_W-1:0] buf_data,
   output logic              irq,
   output logic              underrun
);
   logic [DATA_W-1:0] buf_q;
   logic              full_q;
   logic              irq_q;
   logic              unr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (wr_en) begin
            buf_q  <= wr_data;
            full_q <= 1'b1;
         end else if (load_req) begin
            full_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         unr_q <= 1'b0;
      end else if (!en) begin
         irq_q <= 1'b0;
         unr_q <= 1'b0;
      end else begin
         if (load_req)
            irq_q <= 1'b1;
         else if (wr_en || irq_clr)
            irq_q <= 1'b0;
         if (load_req && !full_q)
            unr_q <= 1'b1;
      end
   end

   assign buf_data = buf_q;
   assign irq      = irq_q;
   assign underrun = unr_q;

   AST_IRQ_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && load_req) |=> irq); // R5
   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (full_q && buf_q == $past(wr_data))); // R4
   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (en && underrun) |=> (underrun || !$past(en))); // R9
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!irq && !underrun)); // R7
endmodule

// File: rtl/vsr_shifter.sv
module vsr_shifter #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rise,
   input  logic [DATA_W-1:0] buf_data,
   output logic              load_req,
   output logic              sd_out
);
   import vsr_pkg::*;

   localparam int              CNT_W    = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_next;
   logic [CNT_W-1:0]  cnt_q;
   logic              en_q;
   logic              sd_q;
   logic              head_bit;
   logic              start;
   logic              frame_end;

   if (MSB_FIRST) begin : g_msb_first
      assign head_bit = sh_q[DATA_W-1];
      assign sh_next  = sh_q << 1;
   end else begin : g_lsb_first
      assign head_bit = sh_q[0];
      assign sh_next  = sh_q >> 1;
   end

   assign start     = en & ~en_q;
   assign frame_end = en & en_q & rise & (cnt_q == ACK_SLOT);
   assign load_req  = start | frame_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sh_q  <= '0;
         cnt_q <= '0;
         sd_q  <= LINE_IDLE;
      end else begin
         en_q <= en;
         if (!en) begin
            cnt_q <= '0;
            sd_q  <= LINE_IDLE;
         end else if (start) begin
            sh_q  <= buf_data;
            cnt_q <= '0;
         end else if (rise) begin
            if (cnt_q == ACK_SLOT) begin
               sd_q  <= LINE_ACK;
               sh_q  <= buf_data;
               cnt_q <= '0;
            end else begin
               sd_q  <= head_bit;
               sh_q  <= sh_next;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign sd_out = sd_q;

   AST_LINE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> sd_out); // R7
   AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rise) |=> $stable(sd_out)); // R2
   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ACK_SLOT); // R1
   AST_ACK_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (!sd_out && cnt_q == '0)); // R1
endmodule

// File: rtl/vsync_ddc_tx.sv
module vsync_ddc_tx #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              irq_clr,
   input  logic              vsync_in,
   output logic              sd_out,
   output logic              irq,
   output logic              underrun
);
   if (DATA_W < 1) begin : g_bad_width
      $error("vsync_ddc_tx: DATA_W must be at least 1");
   end

   logic              rise;
   logic              load_req;
   logic [DATA_W-1:0] buf_data;

   vsr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (vsync_in),
      .rise     (rise)
   );

   vsr_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .irq_clr  (irq_clr),
      .load_req (load_req),
      .buf_data (buf_data),
      .irq      (irq),
      .underrun (underrun)
   );

   vsr_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .rise     (rise),
      .buf_data (buf_data),
      .load_req (load_req),
      .sd_out   (sd_out)
   );
endmodule

// File: tb/sim_vsync_ddc_tx.sv
module sim_vsync_ddc_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       irq_clr = 1'b0;
   logic       vsync_in = 1'b0;
   logic       sd_out;
   logic       irq;
   logic       underrun;
   int         errs = 0;
   int         checks = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   vsync_ddc_tx u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
      .irq_clr(irq_clr), .vsync_in(vsync_in), .sd_out(sd_out), .irq(irq),
      .underrun(underrun)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_byte(input logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; wr_data = b;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic vs_pulse();
      @(negedge clk); vsync_in = 1'b1;
      idle(4);
      vsync_in = 1'b0;
      idle(4);
   endtask

   task automatic send_bits(input logic [7:0] b, input int first, input int last, input string tag);
      for (int i = first; i >= last; i--) begin
         vs_pulse();
         check(tag, {31'b0, sd_out}, {31'b0, b[i]});
      end
   endtask

   task automatic t_reset();
      check("R7 reset sd_out", {31'b0, sd_out}, 32'd1);
      check("R7 reset irq", {31'b0, irq}, 32'd0);
      check("R9 reset underrun", {31'b0, underrun}, 32'd0);
   endtask

   task automatic t_disabled();
      for (int k = 0; k < 3; k++) begin
         vs_pulse();
         check("R7 vsync ignored while off", {31'b0, sd_out}, 32'd1);
      end
      write_byte(8'hA5);
      check("R7 irq stays low while off", {31'b0, irq}, 32'd0);
   endtask

   task automatic t_enable();
      @(negedge clk); en = 1'b1;
      idle(2);
      check("R6 irq after enable load", {31'b0, irq}, 32'd1);
      check("R6 line high before first edge", {31'b0, sd_out}, 32'd1);
      write_byte(8'h3C);
      check("R4 write clears irq", {31'b0, irq}, 32'd0);
   endtask

   task automatic t_frame1();
      send_bits(8'hA5, 7, 7, "R3 first bit A5");
      @(negedge clk); vsync_in = 1'b1;
      idle(2);
      check("R2 no change before sync delay", {31'b0, sd_out}, 32'd1);
      idle(1);
      check("R2 change after sync delay", {31'b0, sd_out}, 32'd0);
      idle(3);
      check("R2 held high no advance", {31'b0, sd_out}, 32'd0);
      vsync_in = 1'b0;
      idle(4);
      check("R2 falling edge no advance", {31'b0, sd_out}, 32'd0);
      send_bits(8'hA5, 5, 0, "R3 A5 bits");
      vs_pulse();
      check("R1 ack slot zero", {31'b0, sd_out}, 32'd0);
      check("R5 irq on frame load", {31'b0, irq}, 32'd1);
      check("R9 no underrun when refilled", {31'b0, underrun}, 32'd0);
   endtask

   task automatic t_frame2();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      check("R8 irq_clr clears", {31'b0, irq}, 32'd0);
      send_bits(8'h3C, 7, 7, "R10 next byte first bit");
      send_bits(8'h3C, 6, 0, "R10 3C bits");
      check("R8 irq stays clear", {31'b0, irq}, 32'd0);
      vs_pulse();
      check("R1 ack slot zero frame 2", {31'b0, sd_out}, 32'd0);
      check("R5 irq on second load", {31'b0, irq}, 32'd1);
      check("R9 underrun set", {31'b0, underrun}, 32'd1);
   endtask

   task automatic t_resend();
      send_bits(8'h3C, 7, 0, "R9 resend old byte");
      write_byte(8'h5A);
      check("R4 write clears irq again", {31'b0, irq}, 32'd0);
      vs_pulse();
      check("R1 ack slot zero frame 3", {31'b0, sd_out}, 32'd0);
      check("R9 underrun sticky", {31'b0, underrun}, 32'd1);
      send_bits(8'h5A, 7, 5, "R10 5A bits");
   endtask

   task automatic t_disable();
      @(negedge clk); en = 1'b0;
      idle(2);
      check("R7 line high after disable", {31'b0, sd_out}, 32'd1);
      check("R7 irq cleared by disable", {31'b0, irq}, 32'd0);
      check("R7 underrun cleared by disable", {31'b0, underrun}, 32'd0);
      vs_pulse();
      check("R7 no shifting while off", {31'b0, sd_out}, 32'd1);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_disabled();
      t_enable();
      t_frame1();
      t_frame2();
      t_resend();
      t_disable();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errs++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule